// File: doc/BRIEF.md
# Serial Register Read-Back Scanner

This block provides read-back of a bank of 12-bit configuration registers and a small set of internal counters through one serial output. It shares the field-indicator (odd/even) output pin. When the loaded address is one of the scan addresses, the block copies the selected word into a private shift register and deasserts the count-clock enable. Every other part of the device stays frozen for the whole readout. The word then leaves on the shared pin one bit per clock, least significant bit first.

The scan address of register n is n plus a fixed offset of 32. The addresses just above the register window select the counters. Loading any address outside the scan window ends the readout, gives the pin back to the normal field signal and restarts the count clock. The block only reads the banks and never writes them, so a readout leaves every register and counter as it was. Address decoding for the rest of the device and the counters themselves are outside this block.

Top module: `scan_readout`

## Requirements
- R1: After reset no scan is active: `scan_sel_o` is 0, `count_clk_en_o` is 1 and `pin_o` follows `field_i`.
- R2: A load of address 32+n, for n from 0 to 18, captures register word n (bits `reg_bank_i[12n+11:12n]`).
- R3: A load of address 51, 52 or 53 captures counter word 0, 1 or 2 (bits `cnt_bank_i[12k+11:12k]`).
- R4: In the cycle after a scan-address load, `count_clk_en_o` is 0 and `scan_sel_o` is 1. Both hold until a non-scan address is loaded.
- R5: Bit 0 of the captured word is on `scan_data_o` and `pin_o` in the cycle after the load. Each later clock without a load presents the next higher bit.
- R6: After the 12 bits have been presented, the serial output is 0 until the next address load.
- R7: A change to the bank inputs after capture does not change the bits being shifted out.
- R8: A load of a non-scan address returns `pin_o` to `field_i` and sets `count_clk_en_o` to 1 from the next cycle.
- R9: While scanning, `pin_o` equals `scan_data_o` and ignores `field_i`. While not scanning, `pin_o` equals `field_i`.
- R10: A scan-address load during a readout recaptures the newly selected word and restarts at its bit 0.
- R11: Addresses 0 to 31 and 54 to 63 never start a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | External clock; one scan bit per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_load_i | input | 1 | A new address is loaded at this edge |
| addr_i | input | 6 | Address being loaded |
| reg_bank_i | input | 228 | 19 register words, word n at bits 12n+11:12n |
| cnt_bank_i | input | 36 | 3 counter words, word k at bits 12k+11:12k |
| field_i | input | 1 | Normal odd/even field signal for the shared pin |
| pin_o | output | 1 | Shared pin: field signal or scan data |
| scan_data_o | output | 1 | Current serial scan bit |
| scan_sel_o | output | 1 | Pin mux select, 1 while a scan is active |
| count_clk_en_o | output | 1 | Count-clock enable, 0 while frozen for a scan |

## Verification
The assertions assume that `addr_i` is meaningful only in a cycle where `addr_load_i` is high. They also assume that the bank words seen at a load edge are the ones to be captured, so the first-bit property samples the banks in that same cycle. The stimulus changes addresses, bank words and `field_i` only at the falling clock edge. This lets each load see stable inputs. Bank words change only after a capture, which exercises the snapshot behaviour without racing the load.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_REG  = 2'd1,
    SRC_CNT  = 2'd2
  } src_kind_e;

  typedef struct packed {
    src_kind_e  kind;
    logic [7:0] idx;
  } scan_hit_t;

endpackage

// File: rtl/scan_decode.sv
module scan_decode
  import scan_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int SCAN_BASE = 32,
  parameter int NUM_REGS  = 19,
  parameter int NUM_CNTS  = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output scan_hit_t         hit_o
);
  localparam int REG_END = SCAN_BASE + NUM_REGS;
  localparam int CNT_END = REG_END + NUM_CNTS;

  always_comb begin
    int a;
    a = int'(32'(addr_i));
    hit_o.kind = SRC_NONE;
    hit_o.idx  = '0;
    if (a >= SCAN_BASE && a < REG_END) begin
      hit_o.kind = SRC_REG;
      hit_o.idx  = 8'(a - SCAN_BASE);
    end else if (a >= REG_END && a < CNT_END) begin
      hit_o.kind = SRC_CNT;
      hit_o.idx  = 8'(a - REG_END);
    end
  end
endmodule

// File: rtl/scan_source_mux.sv
module scan_source_mux
  import scan_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int NUM_REGS = 19,
  parameter int NUM_CNTS = 3
) (
  input  logic [NUM_REGS*DATA_W-1:0] reg_bank_i,
  input  logic [NUM_CNTS*DATA_W-1:0] cnt_bank_i,
  input  scan_hit_t                  hit_i,
  output logic [DATA_W-1:0]          word_o
);
  localparam int NUM_SRC = NUM_REGS + NUM_CNTS;

  logic [DATA_W-1:0] src_w [NUM_SRC];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign src_w[g] = reg_bank_i[g*DATA_W +: DATA_W];
  end
  for (genvar g = 0; g < NUM_CNTS; g++) begin : g_cnt
    assign src_w[NUM_REGS+g] = cnt_bank_i[g*DATA_W +: DATA_W];
  end

  always_comb begin
    int sel;
    sel    = -1;
    word_o = '0;
    case (hit_i.kind)
      SRC_REG: sel = int'(hit_i.idx);
      SRC_CNT: sel = NUM_REGS + int'(hit_i.idx);
      default: sel = -1;
    endcase
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == i) word_o = src_w[i];
    end
  end
endmodule

// File: rtl/scan_shifter.sv
module scan_shifter #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              active_o,
  output logic              bit_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  left_q;
  logic              active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      shreg_q  <= '0;
      left_q   <= '0;
    end else if (load_i) begin
      active_q <= start_i;
      shreg_q  <= start_i ? word_i : '0;
      left_q   <= start_i ? CNT_W'(DATA_W) : '0;
    end else if (active_q && left_q != '0) begin
      // shift in zeros so the tail reads 0
      shreg_q <= {1'b0, shreg_q[DATA_W-1:1]};
      left_q  <= left_q - 1'b1;
    end
  end

  assign active_o = active_q;
  assign bit_o    = shreg_q[0];
endmodule

// File: rtl/scan_readout.sv
module scan_readout
  import scan_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int ADDR_W    = 6,
  parameter int SCAN_BASE = 32,
  parameter int NUM_REGS  = 19,
  parameter int NUM_CNTS  = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       addr_load_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NUM_REGS*DATA_W-1:0] reg_bank_i,
  input  logic [NUM_CNTS*DATA_W-1:0] cnt_bank_i,
  input  logic                       field_i,
  output logic                       pin_o,
  output logic                       scan_data_o,
  output logic                       scan_sel_o,
  output logic                       count_clk_en_o
);
  scan_hit_t         hit;
  logic [DATA_W-1:0] word;
  logic              active;
  logic              sbit;

  scan_decode #(
    .ADDR_W   (ADDR_W),
    .SCAN_BASE(SCAN_BASE),
    .NUM_REGS (NUM_REGS),
    .NUM_CNTS (NUM_CNTS)
  ) u_decode (
    .addr_i(addr_i),
    .hit_o (hit)
  );

  scan_source_mux #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .NUM_CNTS(NUM_CNTS)
  ) u_mux (
    .reg_bank_i(reg_bank_i),
    .cnt_bank_i(cnt_bank_i),
    .hit_i     (hit),
    .word_o    (word)
  );

  scan_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (addr_load_i),
    .start_i (hit.kind != SRC_NONE),
    .word_i  (word),
    .active_o(active),
    .bit_o   (sbit)
  );

  assign scan_data_o    = sbit;
  assign scan_sel_o     = active;
  assign count_clk_en_o = ~active;
  assign pin_o          = active ? sbit : field_i;
endmodule

// File: rtl/scan_readout_chk.sv
module scan_readout_chk #(
  parameter int DATA_W    = 12,
  parameter int ADDR_W    = 6,
  parameter int SCAN_BASE = 32,
  parameter int NUM_REGS  = 19,
  parameter int NUM_CNTS  = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       addr_load_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [NUM_REGS*DATA_W-1:0] reg_bank_i,
  input logic [NUM_CNTS*DATA_W-1:0] cnt_bank_i,
  input logic                       field_i,
  input logic                       pin_o,
  input logic                       scan_data_o,
  input logic                       scan_sel_o,
  input logic                       count_clk_en_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic             load_scan;
  logic             exp_b0;
  logic [CNT_W-1:0] seen_q;

  always_comb begin
    int a;
    a         = int'(32'(addr_i));
    load_scan = 1'b0;
    exp_b0    = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (a == SCAN_BASE + i) begin
        load_scan = 1'b1;
        exp_b0    = reg_bank_i[i*DATA_W];
      end
    end
    for (int k = 0; k < NUM_CNTS; k++) begin
      if (a == SCAN_BASE + NUM_REGS + k) begin
        load_scan = 1'b1;
        exp_b0    = cnt_bank_i[k*DATA_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (addr_load_i) seen_q <= '0;
    else if (scan_sel_o && seen_q < CNT_W'(DATA_W)) seen_q <= seen_q + 1'b1;
  end

  p_enter_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_load_i && load_scan |=> !count_clk_en_o && scan_sel_o);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_load_i |=> $stable(scan_sel_o) && $stable(count_clk_en_o));

  p_lsb_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_load_i && load_scan |=> scan_data_o == $past(exp_b0));

  p_zero_tail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_sel_o && seen_q == CNT_W'(DATA_W) |-> !scan_data_o);

  p_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_load_i && !load_scan |=> count_clk_en_o && !scan_sel_o);

  p_pin_field_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_sel_o |-> pin_o == field_i);

  p_pin_scan_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_sel_o |-> pin_o == scan_data_o);
endmodule

bind scan_readout scan_readout_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .SCAN_BASE(SCAN_BASE),
  .NUM_REGS (NUM_REGS),
  .NUM_CNTS (NUM_CNTS)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_load_i   (addr_load_i),
  .addr_i        (addr_i),
  .reg_bank_i    (reg_bank_i),
  .cnt_bank_i    (cnt_bank_i),
  .field_i       (field_i),
  .pin_o         (pin_o),
  .scan_data_o   (scan_data_o),
  .scan_sel_o    (scan_sel_o),
  .count_clk_en_o(count_clk_en_o)
);

// File: tb/scan_readout_test.sv
`timescale 1ns/1ps
module scan_readout_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         addr_load;
  logic [5:0]   addr;
  logic [227:0] reg_bank;
  logic [35:0]  cnt_bank;
  logic         field;
  logic         pin, sdata, ssel, clken;

  logic [11:0] rv [19];
  logic [11:0] cv [3];

  int checks = 0;
  int fails  = 0;

  logic q[$];
  logic m_act = 1'b0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 19; i++) reg_bank[i*12 +: 12] = rv[i];
    for (int k = 0; k < 3; k++) cnt_bank[k*12 +: 12] = cv[k];
  end

  scan_readout uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .addr_load_i   (addr_load),
    .addr_i        (addr),
    .reg_bank_i    (reg_bank),
    .cnt_bank_i    (cnt_bank),
    .field_i       (field),
    .pin_o         (pin),
    .scan_data_o   (sdata),
    .scan_sel_o    (ssel),
    .count_clk_en_o(clken)
  );

  task automatic report_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog R1: actual=running expected=finished");
    report_and_end();
  end

  task automatic compare(input string tag);
    logic e_pin, e_sel, e_en;
    e_sel = m_act;
    e_en  = ~m_act;
    e_pin = m_act ? ((q.size() > 0) ? q[0] : 1'b0) : field;
    checks++;
    if (pin !== e_pin || ssel !== e_sel || clken !== e_en ||
        (m_act && sdata !== e_pin)) begin
      fails++;
      $display("FAIL %s: actual pin=%b sel=%b en=%b data=%b expected pin=%b sel=%b en=%b",
               tag, pin, ssel, clken, sdata, e_pin, e_sel, e_en);
    end
  endtask

  task automatic cycle(input logic ld, input logic [5:0] a, input string tag);
    logic [11:0] v;
    addr_load = ld;
    addr      = a;
    field     = $urandom_range(0, 1) != 0;
    @(posedge clk);
    if (ld) begin
      q.delete();
      if (a >= 6'd32 && a <= 6'd53) begin
        v = (a < 6'd51) ? rv[a - 6'd32] : cv[a - 6'd51];
        for (int b = 0; b < 12; b++) q.push_back(v[b]);
        m_act = 1'b1;
      end else begin
        m_act = 1'b0;
      end
    end else if (m_act && q.size() > 0) begin
      void'(q.pop_front());
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(1'b0, 6'd0, tag);
  endtask

  initial begin
    for (int i = 0; i < 19; i++) rv[i] = 12'(12'h9C3 ^ (i * 12'h151)) + 12'(i);
    rv[0]  = 12'h801;
    rv[18] = 12'h5A6;
    for (int k = 0; k < 3; k++) cv[k] = 12'(12'h3E7 + k * 12'h2B4);
    cv[2] = 12'hFFF;
    rst_n = 1'b0; addr_load = 1'b0; addr = '0; field = 1'b0;
    repeat (2) @(negedge clk);
    compare("R1 in reset");
    field = 1'b1;
    #1 compare("R1 in reset field");
    rst_n = 1'b1;
    idle(3, "R1 after reset");

    // R2 lowest register, full readout plus zero tail (R5, R6)
    cycle(1'b1, 6'd32, "R2 load reg0");
    idle(15, "R5 R6 reg0 readout");
    cycle(1'b1, 6'd0, "R8 exit");
    idle(2, "R8 field back");

    // R2 highest register, bank changes after capture (R7)
    cycle(1'b1, 6'd50, "R2 load reg18");
    rv[18] = 12'hA59;
    idle(3, "R7 snapshot");
    cv[0] = ~cv[0];
    idle(10, "R7 snapshot tail");

    // R3 counters
    for (int k = 0; k < 3; k++) begin
      cycle(1'b1, 6'(51 + k), "R3 load counter");
      idle(13, "R3 R5 counter readout");
    end
    cycle(1'b1, 6'd5, "R8 exit after counters");
    idle(2, "R8 idle");

    // R10 restart mid-scan
    cycle(1'b1, 6'd40, "R10 first load");
    idle(5, "R10 partial");
    cycle(1'b1, 6'd45, "R10 reload");
    idle(6, "R10 second readout");
    cycle(1'b1, 6'd45, "R10 same address reload");
    idle(3, "R10 restarted");

    // R8 exit mid-scan, R9 pin follows field again
    cycle(1'b1, 6'd19, "R8 mid exit");
    idle(4, "R9 field after exit");

    // R11 non-scan addresses
    cycle(1'b1, 6'd31, "R11 addr31");
    idle(2, "R11 idle");
    cycle(1'b1, 6'd54, "R11 addr54");
    idle(2, "R11 idle");
    cycle(1'b1, 6'd22, "R11 addr22");
    cycle(1'b1, 6'd63, "R11 addr63");
    idle(2, "R11 idle");

    // R4 freeze holds across many idle clocks, held load recaptures
    cycle(1'b1, 6'd33, "R4 load");
    idle(20, "R4 hold");
    for (int i = 0; i < 4; i++) cycle(1'b1, 6'd36, "R10 held load");
    cycle(1'b1, 6'd1, "R8 final exit");
    idle(2, "R9 final");

    report_and_end();
  end
endmodule